// File: doc/BRIEF.md
# Sequential Four-Function Calculator Core

This block is the arithmetic and sequencing core of a small calculator. It works on 11-bit two's complement values and offers four operations: sum, difference, product and integer quotient. Operands arrive on a signed-magnitude bus, one sign bit over a ten-bit magnitude. Single-cycle strobes latch a number, select an operator, ask for equals, or clear the core.

The whole datapath has one 11-bit adder/subtractor. Sum and difference finish on the cycle of the equals strobe. Product and quotient are sequenced by a small state machine and take several cycles. The product uses doubling and conditional addition over the magnitude bits. The quotient uses repeated subtraction of magnitudes. Both end with a sign-fix step that passes through the same adder.

Operator strobes only record a pending choice, and the most recent choice is the one applied. Equals acts only once a fresh number has been latched. The surrounding system is expected to debounce its keys and to render the result itself.

Top module: `seq_calc`

## Requirements
- R1: After reset or a clear strobe, `result` is 0 and `ovf`, `busy` and `done` are low, with no operator and no number pending. A clear strobe is honoured in every state, including while `busy` is high.
- R2: `num_sm` carries the sign in bit 10 (1 = negative) and the magnitude in bits 9:0. An equals strobe after a number strobe, with no operator pending, loads that number as two's complement into `result` and clears `ovf`.
- R3: For an equals strobe handled while idle, `done` is high for exactly the one cycle after the edge that updates `result`. Sum, difference, load and zero-divisor cases update `result` on the equals edge itself.
- R4: `op_sel` encodes 0 = sum, 1 = difference, 2 = product, 3 = quotient. When several operator strobes come before equals, only the last one is applied.
- R5: Sum and difference give `result` ± number modulo 2^11. `ovf` is set exactly when the true value lies outside -1024..1023.
- R6: Product gives the true product modulo 2^11, with `ovf` set when the product lies outside -1024..1023. `busy` is high for exactly 11 cycles before `done`.
- R7: Quotient gives the quotient truncated toward zero, with its sign taken from the XOR of the operand signs. `ovf` is set when the quotient lies outside -1024..1023; -1024 / -1 gives result bits 0x400 with `ovf` high.
- R8: A zero divisor leaves `result` unchanged, sets `ovf`, pulses `done` and never raises `busy`.
- R9: Equals with no number latched since the last equals or clear is ignored: no `done` pulse and no change to `result`.
- R10: While `busy` is high, number, operator and equals strobes are ignored. A number strobed during a run is not kept for a later equals.
- R11: `ovf` describes the most recent completed equals and keeps its value until the next one or a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| num_sm | input | 11 | Signed-magnitude number: sign bit 10, magnitude bits 9:0 |
| num_stb | input | 1 | Latch `num_sm` |
| op_sel | input | 2 | Operator code |
| op_stb | input | 1 | Record `op_sel` as the pending operator |
| eq_stb | input | 1 | Apply the pending operator, or load the number |
| clr_stb | input | 1 | Return to the initial state |
| result | output | 11 | Two's complement result register |
| ovf | output | 1 | Result left the 11-bit signed range |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | One-cycle pulse marking a completed equals |

## Verification
Some properties are checked on every cycle. The clear leaves the core at rest. `result` only moves on a clear or together with `done`. A zero divisor completes at once with overflow. `done` and `busy` never overlap. An equals with no fresh number produces nothing. Strobes during a run leave no operator or number pending.

Other behaviour needs the bench's scenarios, because it depends on arithmetic values. This covers the values of results and overflow over a sweep of operand pairs for all four operators, the exact product run length, last-operator-wins, the -1024 boundary cases, and the effect of strobes sent during a long quotient run.

// File: rtl/seq_calc.sv
module seq_calc #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] num_sm,
  input  logic         num_stb,
  input  logic [1:0]   op_sel,
  input  logic         op_stb,
  input  logic         eq_stb,
  input  logic         clr_stb,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         busy,
  output logic         done
);

  localparam int CW = $clog2(W);
  localparam logic [1:0] OP_MUL = 2'd2, OP_QUO = 2'd3;
  localparam logic [W-1:0] LIM_P = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] LIM_N = {1'b1, {(W-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_DIV, S_FIN} st_t;

  st_t          st;
  logic [1:0]   pend_op;
  logic         pend_v, have_num, n_sign, neg, sticky;
  logic [W-2:0] n_mag;
  logic [W-1:0] r1, r2;
  logic [CW-1:0] cnt;

  logic [W-1:0] ad_a, ad_b, sum;
  logic         ad_sub, cout, as_ovf, go;

  always_comb begin
    ad_a = '0;
    ad_b = '0;
    ad_sub = 1'b0;
    case (st)
      S_MUL: begin
        ad_a = {r2[W-2:0], 1'b0};
        ad_b = n_mag[W-2] ? r1 : '0;
      end
      S_DIV: begin
        ad_a = r1;
        ad_b = {1'b0, n_mag};
        ad_sub = 1'b1;
      end
      S_FIN: begin
        ad_b = r2;
        ad_sub = neg;
      end
      default: begin
        if (pend_v && !pend_op[1]) begin
          ad_a = result;
          ad_b = {1'b0, n_mag};
          ad_sub = pend_op[0] ^ n_sign;
        end else if (pend_v) begin
          ad_b = result;
          ad_sub = result[W-1];
        end else begin
          ad_b = {1'b0, n_mag};
          ad_sub = n_sign;
        end
      end
    endcase
  end

  assign {cout, sum} = {1'b0, ad_a} + {1'b0, ad_sub ? ~ad_b : ad_b} + {{W{1'b0}}, ad_sub};
  assign as_ovf = (ad_a[W-1] == (ad_b[W-1] ^ ad_sub)) && (sum[W-1] != ad_a[W-1]);
  assign go = eq_stb && have_num && (st == S_IDLE);
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_stb) begin
      st <= S_IDLE;
      result <= '0;
      ovf <= 1'b0;
      done <= 1'b0;
      pend_op <= '0;
      pend_v <= 1'b0;
      have_num <= 1'b0;
      n_sign <= 1'b0;
      n_mag <= '0;
      neg <= 1'b0;
      sticky <= 1'b0;
      r1 <= '0;
      r2 <= '0;
      cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (op_stb) begin
            pend_op <= op_sel;
            pend_v <= 1'b1;
          end
          if (num_stb) begin
            n_sign <= num_sm[W-1];
            n_mag <= num_sm[W-2:0];
            have_num <= 1'b1;
          end
          if (go) begin
            have_num <= 1'b0;
            pend_v <= 1'b0;
            if (!pend_v || !pend_op[1]) begin
              result <= sum;
              ovf <= pend_v && as_ovf;
              done <= 1'b1;
            end else begin
              neg <= result[W-1] ^ n_sign;
              sticky <= 1'b0;
              r1 <= sum;
              r2 <= '0;
              if (pend_op == OP_MUL) begin
                cnt <= CW'(W-1);
                st <= S_MUL;
              end else if (n_mag == '0) begin
                ovf <= 1'b1;
                done <= 1'b1;
              end else begin
                st <= S_DIV;
              end
            end
          end
        end
        S_MUL: begin
          r2 <= sum;
          sticky <= sticky | r2[W-1] | cout;
          n_mag <= n_mag << 1;
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= S_FIN;
        end
        S_DIV: begin
          if (cout) begin
            r1 <= sum;
            r2 <= r2 + W'(1);
          end else begin
            st <= S_FIN;
          end
        end
        default: begin
          result <= sum;
          ovf <= sticky | (r2 > (neg ? LIM_N : LIM_P));
          done <= 1'b1;
          st <= S_IDLE;
        end
      endcase
    end
  end

  a_r1_clear_rest: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> (result == '0) && !ovf && !busy && !done && !pend_v && !have_num);

  a_r3_result_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stb |=> ($stable(result) || done));

  a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (go && pend_v && pend_op == OP_QUO && n_mag == '0 && !clr_stb)
      |=> ovf && done && !busy && $stable(result));

  a_r9_eq_without_number: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_stb && !have_num && st == S_IDLE && !clr_stb) |=> !done);

  a_r10_busy_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr_stb) |=> !pend_v && !have_num);

endmodule

// File: tb/seq_calc_test.sv
module seq_calc_test;
  localparam int W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] num_sm = '0;
  logic num_stb = 1'b0, op_stb = 1'b0, eq_stb = 1'b0, clr_stb = 1'b0;
  logic [1:0] op_sel = '0;
  logic [W-1:0] result;
  logic ovf, busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  seq_calc #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .num_sm(num_sm), .num_stb(num_stb),
    .op_sel(op_sel), .op_stb(op_stb), .eq_stb(eq_stb), .clr_stb(clr_stb),
    .result(result), .ovf(ovf), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] to_sm(input int v);
    int m;
    m = (v < 0) ? -v : v;
    return {v < 0, m[W-2:0]};
  endfunction

  task automatic put_num(input int v);
    @(negedge clk); num_sm = to_sm(v); num_stb = 1'b1;
    @(negedge clk); num_stb = 1'b0;
  endtask

  task automatic put_op(input int o);
    @(negedge clk); op_sel = 2'(o); op_stb = 1'b1;
    @(negedge clk); op_stb = 1'b0;
  endtask

  task automatic press_eq();
    @(negedge clk); eq_stb = 1'b1;
    @(negedge clk); eq_stb = 1'b0;
  endtask

  task automatic press_clr();
    @(negedge clk); clr_stb = 1'b1;
    @(negedge clk); clr_stb = 1'b0;
  endtask

  task automatic wait_done(output int bcyc, output bit got);
    bcyc = 0;
    got = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin
        got = 1'b1;
        break;
      end
      if (busy) bcyc++;
      else if (bcyc > 0 || i > 2) break;
      @(negedge clk);
    end
  endtask

  task automatic do_eq(output int bcyc, output bit got);
    press_eq();
    wait_done(bcyc, got);
  endtask

  task automatic model(input int a, input int o, input int b, output int res, output bit ov);
    int t;
    if (o == 3 && b == 0) begin
      res = a & 2047;
      ov = 1'b1;
      return;
    end
    case (o)
      0: t = a + b;
      1: t = a - b;
      2: t = a * b;
      default: t = a / b;
    endcase
    res = t & 2047;
    ov = (t < -1024) || (t > 1023);
  endtask

  task automatic run_pair(input int a, input int o, input int b, input string tag);
    int bc, er;
    bit got, eo;
    press_clr();
    put_num(a);
    do_eq(bc, got);
    put_op(o);
    put_num(b);
    do_eq(bc, got);
    model(a, o, b, er, eo);
    check(got, {tag, " done"}, got, 1);
    check(int'(result) == er, {tag, " result"}, int'(result), er);
    check(ovf == eo, {tag, " ovf"}, ovf, eo);
    if (o == 2) check(bc == 11, "R6 busy length", bc, 11);
  endtask

  initial begin
    int bc;
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(result == '0 && !ovf && !busy && !done, "R1 reset", int'(result), 0);

    // R2 R3 load and done timing
    put_num(-37);
    press_eq();
    check(done && int'(result) == (-37 & 2047), "R2 load -37", int'(result), -37 & 2047);
    @(negedge clk);
    check(!done, "R3 done single cycle", done, 0);

    // R4 last operator wins, typical chain
    press_clr();
    put_num(5); do_eq(bc, got);
    check(int'(result) == 5, "R2 load 5", int'(result), 5);
    put_op(1); put_op(3); put_op(2);
    put_num(7); do_eq(bc, got);
    check(int'(result) == 35, "R4 last op mul", int'(result), 35);
    put_op(1); put_num(5); do_eq(bc, got);
    check(int'(result) == 30, "R5 35-5", int'(result), 30);
    put_op(3); put_num(4); do_eq(bc, got);
    check(int'(result) == 7, "R7 30/4", int'(result), 7);
    press_clr();
    check(int'(result) == 0 && !ovf, "R1 clear", int'(result), 0);

    // R7 -1024 corners and R6 boundaries
    put_num(-1023); do_eq(bc, got);
    put_op(1); put_num(1); do_eq(bc, got);
    check(int'(result) == 1024 && !ovf, "R5 reach -1024", int'(result), 1024);
    put_op(3); put_num(-1); do_eq(bc, got);
    check(int'(result) == 1024 && ovf, "R7 -1024/-1 ovf", int'(result) + 4096 * ovf, 1024 + 4096);
    press_clr();
    put_num(-1023); do_eq(bc, got);
    put_op(1); put_num(1); do_eq(bc, got);
    put_op(2); put_num(1); do_eq(bc, got);
    check(int'(result) == 1024 && !ovf, "R6 -1024*1", int'(result) + 4096 * ovf, 1024);
    put_op(2); put_num(-1); do_eq(bc, got);
    check(int'(result) == 1024 && ovf, "R6 -1024*-1 ovf", int'(result) + 4096 * ovf, 1024 + 4096);

    // R8 zero divisor, R11 ovf tracks last equals
    press_clr();
    put_num(100); do_eq(bc, got);
    put_op(3); put_num(0); do_eq(bc, got);
    check(got && bc == 0, "R8 zero div no busy", bc, 0);
    check(int'(result) == 100 && ovf, "R8 zero div", int'(result) + 4096 * ovf, 100 + 4096);
    repeat (3) @(negedge clk);
    check(ovf, "R11 ovf held", ovf, 1);
    put_op(0); put_num(1); do_eq(bc, got);
    check(int'(result) == 101 && !ovf, "R11 ovf cleared", int'(result) + 4096 * ovf, 101);

    // R9 equals without a new number
    do_eq(bc, got);
    check(!got && int'(result) == 101, "R9 eq ignored", int'(result) + 4096 * got, 101);

    // R10 strobes during a long quotient run
    press_clr();
    put_num(1023); do_eq(bc, got);
    put_op(3); put_num(1);
    press_eq();
    put_num(5); put_op(0);
    @(negedge clk); eq_stb = 1'b1; @(negedge clk); eq_stb = 1'b0;
    check(busy, "R10 still busy", busy, 1);
    wait_done(bc, got);
    check(got && int'(result) == 1023, "R10 1023/1", int'(result), 1023);
    do_eq(bc, got);
    check(!got && int'(result) == 1023, "R10 number dropped", int'(result) + 4096 * got, 1023);

    // R1 clear during a run
    press_clr();
    put_num(1000); do_eq(bc, got);
    put_op(3); put_num(1);
    press_eq();
    repeat (20) @(negedge clk);
    press_clr();
    check(!busy && int'(result) == 0 && !ovf, "R1 clear while busy", int'(result) + 4096 * busy, 0);

    // sweep over operand pairs: R5 R6 R7
    for (int a = -1023; a <= 1023; a += 73) begin
      for (int b = -1023; b <= 1023; b += 97) begin
        for (int o = 0; o < 4; o++) begin
          run_pair(a, o, b, o < 2 ? "R5 sweep" : (o == 2 ? "R6 sweep" : "R7 sweep"));
        end
      end
    end
    run_pair(0, 2, -5, "R6 zero times neg");
    run_pair(-7, 3, 2, "R7 trunc toward zero");
    run_pair(3, 3, -7, "R7 small quotient");
    run_pair(1023, 0, 1, "R5 add overflow");
    run_pair(-1023, 1, 1023, "R5 sub overflow");
    run_pair(32, 2, 32, "R6 product 1024");
    run_pair(-32, 2, 32, "R6 product -1024");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule